// File: doc/BRIEF.md
# Tracking Brake Direction Switch

This block sits between the tracking equalizer and the tracking actuator driver of an optical disc servo. While the tracking loop is being pulled in after a seek or track jump, the lens slides across tracks. The block works out which way the lens is travelling and blanks any equalizer drive that would push the lens further in that direction. Drive that opposes the travel passes, so the lens is braked.

The sign of the tracking-error sample is squared up into a zero-cross level, with a programmable dead band around zero to reject chatter. On every change of that level, the on/off-track flag is captured. Because the phase between the two signals reverses with the direction of travel, the captured flag combined with the new level gives the direction. When braking is disabled, the equalizer sample passes straight through. Direction tracking keeps running while braking is disabled.

Top module: `tbrk_switch`

## Requirements
- R1: While `rst` is high at a clock edge, `tzc_o`, `dir_o` and `swp_o` become 0 and `drive_o` becomes 0.
- R2: `tzc_o` becomes 1 at the clock edge where the signed `te_i` is strictly greater than `hyst_i`.
- R3: `tzc_o` becomes 0 at the clock edge where `te_i` is strictly less than −`hyst_i`. For any value from −`hyst_i` to +`hyst_i` inclusive, `tzc_o` keeps its value.
- R4: At every clock edge where `tzc_o` changes, `swp_o` takes the value of `mirr_i` (1 = off track, 0 = on track) present at that edge. At all other edges, `mirr_i` is ignored and `swp_o` and `dir_o` hold.
- R5: At a change of `tzc_o`, `dir_o` becomes 1 (outward) when the captured `mirr_i` equals the new level of `tzc_o`: a rising level with the flag high, or a falling level with the flag low. Otherwise `dir_o` becomes 0 (inward).
- R6: With `en_i` high, `drive_o` at each edge depends on `eq_i` at that edge and on `dir_o` as it stood before that edge. If that direction is 1, `drive_o` is `eq_i` when `eq_i` is negative and 0 otherwise. If that direction is 0, `drive_o` is `eq_i` when `eq_i` is positive and 0 otherwise.
- R7: With `en_i` low, `drive_o` equals `eq_i` one edge later regardless of direction. Zero-cross and direction tracking continue while `en_i` is low.
- R8: `hyst_i` is an input: with `hyst_i` = 0, `te_i` = 0 holds `tzc_o`, and ±1 is enough to flip it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Braking enable; low passes the equalizer sample through |
| te_i | input | TE_W | Signed tracking-error sample |
| hyst_i | input | TE_W-1 | Half-width of the dead band around zero |
| mirr_i | input | 1 | On/off-track flag, 1 = off track |
| eq_i | input | EQ_W | Signed tracking equalizer output |
| drive_o | output | EQ_W | Signed gated drive to the actuator |
| tzc_o | output | 1 | Squared zero-cross level |
| swp_o | output | 1 | Switching pulse: track flag captured at the last level change |
| dir_o | output | 1 | Travel direction, 1 = outward, 0 = inward |

## Verification
The vector walk first moves the tracking error through a rising and a falling crossing with the flag in outward phase, then repeats that with the flag in inward phase. The dead-band rows distinguish a strict threshold from an inclusive one. The equalizer sign is varied against each direction, which shows whether the gate uses the direction from before the edge or after it. Directed steps then cover pass-through with a direction that would otherwise blank, direction updates while disabled, a zero-width dead band, and a reset in mid-run.

// File: rtl/tbrk_pkg.sv
package tbrk_pkg;

    typedef enum logic {
        DIR_INWARD  = 1'b0,
        DIR_OUTWARD = 1'b1
    } dir_e;

    typedef struct packed {
        logic level;
        logic flip;
    } zc_t;

    // New squared level from the band decision.
    function automatic logic zc_decide(input logic above, input logic below,
                                       input logic cur);
        if (above)      return 1'b1;
        else if (below) return 1'b0;
        else            return cur;
    endfunction

    // Outward travel is opposed by negative drive, inward by positive drive.
    function automatic logic drive_opposes(input dir_e d, input logic neg,
                                           input logic nonzero);
        if (d == DIR_OUTWARD) return neg;
        else                  return nonzero && !neg;
    endfunction

    // Direction from the captured track flag and the new squared level.
    function automatic dir_e dir_from_phase(input logic flag, input logic level);
        return (flag == level) ? DIR_OUTWARD : DIR_INWARD;
    endfunction

endpackage

// File: rtl/tbrk_zero_cross.sv
module tbrk_zero_cross
    import tbrk_pkg::*;
#(
    parameter int TE_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [TE_W-1:0] te_i,
    input  logic [TE_W-2:0]        hyst_i,
    output zc_t                    zc_next_o,
    output logic                   level_o
);
    logic signed [TE_W-1:0] band_hi;
    logic signed [TE_W-1:0] band_lo;
    logic                   above;
    logic                   below;
    logic                   level_q;

    always_comb begin
        band_hi = signed'({1'b0, hyst_i});
        band_lo = -band_hi;
        above   = te_i > band_hi;
        below   = te_i < band_lo;
        zc_next_o.level = zc_decide(above, below, level_q);
        zc_next_o.flip  = zc_next_o.level != level_q;
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= zc_next_o.level;
    end

    assign level_o = level_q;

    // R2
    zc_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (te_i > signed'({1'b0, hyst_i})) |=> level_q);
    // R3
    zc_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (te_i < -signed'({1'b0, hyst_i})) |=> !level_q);
    // R3
    zc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((te_i <= signed'({1'b0, hyst_i})) && (te_i >= -signed'({1'b0, hyst_i})))
        |=> $stable(level_q));
endmodule

// File: rtl/tbrk_dir_latch.sv
module tbrk_dir_latch
    import tbrk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  zc_t  zc_i,
    input  logic mirr_i,
    output logic swp_o,
    output dir_e dir_o
);
    logic swp_q;
    dir_e dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            swp_q <= 1'b0;
            dir_q <= DIR_INWARD;
        end else if (zc_i.flip) begin
            swp_q <= mirr_i;
            dir_q <= dir_from_phase(mirr_i, zc_i.level);
        end
    end

    assign swp_o = swp_q;
    assign dir_o = dir_q;

    // R4
    swp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !zc_i.flip |=> ($stable(swp_q) && $stable(dir_q)));
    // R4
    swp_capture_chk: assert property (@(posedge clk) disable iff (rst)
        zc_i.flip |=> (swp_q == $past(mirr_i)));
endmodule

// File: rtl/tbrk_drive_gate.sv
module tbrk_drive_gate
    import tbrk_pkg::*;
#(
    parameter int EQ_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en_i,
    input  dir_e                   dir_i,
    input  logic signed [EQ_W-1:0] eq_i,
    output logic signed [EQ_W-1:0] drive_o
);
    localparam int SIGN_BIT = EQ_W - 1;

    logic                   keep;
    logic signed [EQ_W-1:0] drive_d;
    logic signed [EQ_W-1:0] drive_q;

    always_comb begin
        keep    = drive_opposes(dir_i, eq_i[SIGN_BIT], |eq_i);
        drive_d = (!en_i || keep) ? eq_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) drive_q <= '0;
        else     drive_q <= drive_d;
    end

    assign drive_o = drive_q;

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (drive_q == $past(eq_i)));
    // R6
    gate_value_chk: assert property (@(posedge clk) disable iff (rst)
        en_i |=> ((drive_q == '0) || (drive_q == $past(eq_i))));
    // R6
    gate_out_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && dir_i == DIR_OUTWARD && !eq_i[SIGN_BIT]) |=> (drive_q == '0));
    // R6
    gate_in_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && dir_i == DIR_INWARD && eq_i[SIGN_BIT]) |=> (drive_q == '0));
endmodule

// File: rtl/tbrk_switch.sv
module tbrk_switch
    import tbrk_pkg::*;
#(
    parameter int TE_W = 12,
    parameter int EQ_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en_i,
    input  logic signed [TE_W-1:0] te_i,
    input  logic [TE_W-2:0]        hyst_i,
    input  logic                   mirr_i,
    input  logic signed [EQ_W-1:0] eq_i,
    output logic signed [EQ_W-1:0] drive_o,
    output logic                   tzc_o,
    output logic                   swp_o,
    output logic                   dir_o
);
    zc_t  zc_next;
    dir_e dir_now;

    tbrk_zero_cross #(.TE_W(TE_W)) u_zc (
        .clk       (clk),
        .rst       (rst),
        .te_i      (te_i),
        .hyst_i    (hyst_i),
        .zc_next_o (zc_next),
        .level_o   (tzc_o)
    );

    tbrk_dir_latch u_dir (
        .clk    (clk),
        .rst    (rst),
        .zc_i   (zc_next),
        .mirr_i (mirr_i),
        .swp_o  (swp_o),
        .dir_o  (dir_now)
    );

    tbrk_drive_gate #(.EQ_W(EQ_W)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .dir_i   (dir_now),
        .eq_i    (eq_i),
        .drive_o (drive_o)
    );

    assign dir_o = dir_now;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!tzc_o && !swp_o && !dir_o && drive_o == '0));
    // R5
    dir_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (tzc_o != $past(tzc_o)) |-> (dir_o == (swp_o == tzc_o)));
endmodule

// File: tb/tb_tbrk_switch.sv
`timescale 1ns/1ps
module tb_tbrk_switch;
    localparam int TE_W = 12;
    localparam int EQ_W = 12;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   en_i = 1'b1;
    logic signed [TE_W-1:0] te_i = '0;
    logic [TE_W-2:0]        hyst_i = 11'd8;
    logic                   mirr_i = 1'b0;
    logic signed [EQ_W-1:0] eq_i = '0;
    logic signed [EQ_W-1:0] drive_o;
    logic                   tzc_o, swp_o, dir_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tbrk_switch #(.TE_W(TE_W), .EQ_W(EQ_W)) dut (
        .clk(clk), .rst(rst), .en_i(en_i), .te_i(te_i), .hyst_i(hyst_i),
        .mirr_i(mirr_i), .eq_i(eq_i), .drive_o(drive_o), .tzc_o(tzc_o),
        .swp_o(swp_o), .dir_o(dir_o)
    );

    typedef struct packed {
        logic signed [11:0] te;
        logic               mirr;
        logic signed [11:0] eq;
        logic               tzc;
        logic               dir;
        logic               swp;
        logic signed [11:0] drv;
    } vec_t;

    // Dead band 8, braking enabled. Expected outputs after the edge.
    localparam vec_t VEC [13] = '{
        '{12'sd5,     1'b0, 12'sd100,   1'b0, 1'b0, 1'b0, 12'sd100},
        '{12'sd20,    1'b1, -12'sd50,   1'b1, 1'b1, 1'b1, 12'sd0},
        '{12'sd3,     1'b0, -12'sd50,   1'b1, 1'b1, 1'b1, -12'sd50},
        '{-12'sd5,    1'b0, 12'sd70,    1'b1, 1'b1, 1'b1, 12'sd0},
        '{-12'sd9,    1'b0, 12'sd70,    1'b0, 1'b1, 1'b0, 12'sd0},
        '{-12'sd30,   1'b1, -12'sd20,   1'b0, 1'b1, 1'b0, -12'sd20},
        '{12'sd9,     1'b0, -12'sd20,   1'b1, 1'b0, 1'b0, -12'sd20},
        '{12'sd0,     1'b1, -12'sd20,   1'b1, 1'b0, 1'b0, 12'sd0},
        '{-12'sd8,    1'b1, 12'sd40,    1'b1, 1'b0, 1'b0, 12'sd40},
        '{-12'sd100,  1'b1, 12'sd40,    1'b0, 1'b0, 1'b1, 12'sd40},
        '{12'sd8,     1'b1, 12'sd0,     1'b0, 1'b0, 1'b1, 12'sd0},
        '{12'sd2047,  1'b1, -12'sd2048, 1'b1, 1'b1, 1'b1, 12'sd0},
        '{-12'sd2048, 1'b0, -12'sd2048, 1'b0, 1'b1, 1'b0, -12'sd2048}
    };

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic signed [11:0] te, input logic m,
                        input logic signed [11:0] eq);
        te_i = te; mirr_i = m; eq_i = eq;
        @(posedge clk); #1;
    endtask

    task automatic expect_all(input string req, input logic t, input logic d,
                              input logic s, input int drv);
        check(req, "tzc_o", int'(tzc_o), int'(t));
        check(req, "dir_o", int'(dir_o), int'(d));
        check(req, "swp_o", int'(swp_o), int'(s));
        check(req, "drive_o", int'(drive_o), drv);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin : main
        // R1: reset state
        rst = 1'b1; te_i = 12'sd500; eq_i = 12'sd33; mirr_i = 1'b1;
        repeat (2) @(posedge clk); #1;
        expect_all("R1", 1'b0, 1'b0, 1'b0, 0);
        rst = 1'b0;

        // R2 R3 R4 R5 R6: vector walk
        foreach (VEC[i]) begin
            step(VEC[i].te, VEC[i].mirr, VEC[i].eq);
            check("R2/R3", $sformatf("row %0d tzc_o", i), int'(tzc_o), int'(VEC[i].tzc));
            check("R5",    $sformatf("row %0d dir_o", i), int'(dir_o), int'(VEC[i].dir));
            check("R4",    $sformatf("row %0d swp_o", i), int'(swp_o), int'(VEC[i].swp));
            check("R6",    $sformatf("row %0d drive_o", i), int'(drive_o), int'(VEC[i].drv));
        end

        // R7: disabled passes positive drive though outward direction would blank it
        en_i = 1'b0;
        step(-12'sd50, 1'b1, 12'sd300);
        expect_all("R7", 1'b0, 1'b1, 1'b0, 300);
        // R7: direction tracking continues while disabled (rising, flag high)
        step(12'sd50, 1'b1, -12'sd7);
        expect_all("R7", 1'b1, 1'b1, 1'b1, -7);

        // R8: zero-width dead band
        en_i = 1'b1; hyst_i = '0;
        step(12'sd0, 1'b0, -12'sd5);
        expect_all("R8", 1'b1, 1'b1, 1'b1, -5);
        step(-12'sd1, 1'b1, 12'sd5);
        expect_all("R8", 1'b0, 1'b0, 1'b1, 0);
        step(12'sd1, 1'b1, 12'sd5);
        expect_all("R8", 1'b1, 1'b1, 1'b1, 5);

        // R1: reset in mid-run
        rst = 1'b1;
        step(12'sd100, 1'b1, 12'sd9);
        expect_all("R1", 1'b0, 1'b0, 1'b0, 0);
        rst = 1'b0;

        done = 1'b1;
        finish_run();
    end
endmodule